// File: doc/BRIEF.md
# Muller Handshake Pipeline Controller

This block is a chain of self-timed control stages that moves data items through a short pipeline under a four-phase request/acknowledge protocol. Each stage holds one state bit. It is set when the stage to its left requests and the stage to its right has released its acknowledge. It is cleared when both of those conditions have returned to zero. Otherwise the stage keeps its value. The state bit of a stage is both the request to the stage on its right and the acknowledge to the stage on its left. A data register beside each stage loads the item offered by its left neighbour when the stage state rises. Data therefore moves in lock step with the request events, on wires separate from the control wires.

The chain is built as a clocked emulation. Each stage is a two-state machine with the states `C_EMPTY` (output 0) and `C_FULL` (output 1). There are two named transitions. `RISE` goes from `C_EMPTY` to `C_FULL` when the left request is 1 and the right acknowledge is 0. `FALL` goes from `C_FULL` to `C_EMPTY` when the left request is 0 and the right acknowledge is 1. In every other case the stage stays where it is. All stages update together on the same clock edge from the values their neighbours held in the previous cycle, so an event advances one stage per clock.

A sender drives `req_in` and `data_in` and watches `ack_out`. A receiver watches `req_out` and `data_out` and answers on `ack_in`. When the receiver stalls, the chain fills. Because a Muller chain keeps a bubble between tokens, it holds half as many items as it has stages.

Top module: `muller_pipe_ctrl`

## Requirements
- R1: After reset every stage is in `C_EMPTY` and every data register is zero, so `req_out`, `ack_out` and `data_out` are all 0.
- R2: A stage takes `RISE` on the next clock when its left request is 1 and its right acknowledge is 0. It takes `FALL` on the next clock when its left request is 0 and its right acknowledge is 1.
- R3: A stage whose left request equals its right acknowledge keeps its output unchanged on the next clock.
- R4: Each stage output is the request to the stage on its right and the acknowledge to the stage on its left. In an empty pipeline, `ack_out` rises one clock after `req_in` is seen high, and `req_out` rises `N` clocks after `req_in` is seen high.
- R5: A stage data register loads its left neighbour's data (or `data_in` for the first stage) only on the clock where its stage takes `RISE`. On all other clocks, including `FALL`, it holds its value.
- R6: While `req_out` is 1, `data_out` carries the oldest item not yet acknowledged. Items leave in the order they were accepted, with none lost and none duplicated.
- R7: If `ack_in` is held at 0 while the sender keeps requesting, `ack_out` rises exactly ceil(N/2) times and then stops toggling. Releasing `ack_in` afterwards delivers every accepted item in order.
- R8: At both ends the four-phase order holds. `req_out` falls only on a clock where `ack_in` was 1, and `req_out` rises only on a clock where `ack_in` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock; every stage evaluates once per rising edge |
| rst_n | input | 1 | Active-low synchronous reset; empties the pipeline |
| req_in | input | 1 | Request from the sender, four-phase |
| ack_out | output | 1 | Acknowledge to the sender (first stage state) |
| data_in | input | DATA_W | Item bundled with `req_in` |
| req_out | output | 1 | Request to the receiver (last stage state) |
| ack_in | input | 1 | Acknowledge from the receiver, four-phase |
| data_out | output | DATA_W | Item bundled with `req_out` (last stage register) |

## Verification
The assertions assume the sender behaves as a correct four-phase partner. It raises `req_in` only while `ack_out` is low and lowers it only after `ack_out` is high. It also keeps `data_in` unchanged for as long as `req_in` stays high, which is the bundling rule the first data register relies on. The bench's sender task sets up `data_in` a full clock before it raises `req_in`, and it changes data only after the acknowledge has returned to zero. The bench's receiver raises `ack_in` only while `req_out` is high and lowers it only after `req_out` has fallen, so the right-end ordering also holds. Across the run, gaps between items and acknowledge delays vary, and one window stalls the receiver to fill the chain.

// File: rtl/mp_pkg.sv
package mp_pkg;

    // Two-state view of one C-element: output 0 or output 1.
    typedef enum logic {
        C_EMPTY = 1'b0,
        C_FULL  = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/mp_celement.sv
module mp_celement
    import mp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_left,
    input  logic ack_right,
    output logic ctl,
    output logic ctl_rise
);

    ctl_state_t state_q;
    ctl_state_t state_d;
    logic       fwd_ok;

    // Second C-element input is the inverted acknowledge from the right.
    assign fwd_ok = ~ack_right;

    // Next-state: RISE when both inputs are 1, FALL when both are 0.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_EMPTY: if (req_left && fwd_ok)   state_d = C_FULL;
            C_FULL:  if (!req_left && !fwd_ok) state_d = C_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= C_EMPTY;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        ctl      = (state_q == C_FULL);
        ctl_rise = (state_q == C_EMPTY) && (state_d == C_FULL);
    end

    p_rise_on_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_left && !ack_right) |=> ctl);
    p_fall_on_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_left && ack_right) |=> !ctl);
    p_hold_on_differ_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_left == ack_right) |=> $stable(ctl));

endmodule

// File: rtl/mp_data_latch.sv
module mp_data_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/mp_stage.sv
module mp_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_left,
    input  logic              ack_right,
    input  logic [DATA_W-1:0] data_left,
    output logic              ctl,
    output logic [DATA_W-1:0] data_q
);

    logic rise;

    mp_celement u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_left  (req_left),
        .ack_right (ack_right),
        .ctl       (ctl),
        .ctl_rise  (rise)
    );

    mp_data_latch #(.DATA_W(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rise),
        .d     (data_left),
        .q     (data_q)
    );

endmodule

// File: rtl/muller_pipe_ctrl.sv
module muller_pipe_ctrl #(
    parameter int N_STAGES = 4,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_in,
    output logic              ack_out,
    input  logic [DATA_W-1:0] data_in,
    output logic              req_out,
    input  logic              ack_in,
    output logic [DATA_W-1:0] data_out
);

    localparam int LAST = N_STAGES - 1;

    // req_bus[i] feeds stage i from the left; ack_bus[i+1] feeds it from the right.
    logic [N_STAGES:0]             req_bus;
    logic [N_STAGES:0]             ack_bus;
    logic [DATA_W-1:0]             data_bus [N_STAGES+1];

    assign req_bus[0]      = req_in;
    assign ack_bus[N_STAGES] = ack_in;
    assign data_bus[0]     = data_in;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        logic ctl_i;
        mp_stage #(.DATA_W(DATA_W)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_left  (req_bus[i]),
            .ack_right (ack_bus[i+1]),
            .data_left (data_bus[i]),
            .ctl       (ctl_i),
            .data_q    (data_bus[i+1])
        );
        // One wire, two roles: request rightwards, acknowledge leftwards.
        assign req_bus[i+1] = ctl_i;
        assign ack_bus[i]   = ctl_i;
    end

    assign ack_out  = ack_bus[0];
    assign req_out  = req_bus[N_STAGES];
    assign data_out = data_bus[N_STAGES];

    // Sender-side protocol assumptions.
    p_req_rise_proto_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_in) |-> !ack_out);
    p_bundle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in && $past(req_in)) |-> $stable(data_in));
    // Receiver-side ordering produced by the last stage.
    p_out_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_out) |-> $past(ack_in));
    p_out_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_out) |-> !$past(ack_in));
    // A token reaches the last stage only from a full predecessor (R4).
    p_advance_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_out) |-> $past(req_bus[LAST]));

endmodule

// File: tb/muller_pipe_ctrl_test.sv
`timescale 1ns/1ps
module muller_pipe_ctrl_test;

    localparam int N  = 4;
    localparam int W  = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_in, ack_in;
    logic         ack_out, req_out;
    logic [W-1:0] data_in, data_out;

    int n_checks = 0;
    int n_fail   = 0;
    int tx_count = 0;
    int rx_count = 0;
    logic hold_ack = 1'b0;
    logic finished = 1'b0;
    logic [W-1:0] exp_q [$];

    always #10 clk = ~clk;   // 50 MHz

    muller_pipe_ctrl #(.N_STAGES(N), .DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_in(req_in), .ack_out(ack_out), .data_in(data_in),
        .req_out(req_out), .ack_in(ack_in), .data_out(data_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: four-phase sender, pushes the expected item as it requests.
    task automatic send_item(input logic [W-1:0] v, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk); data_in = v;
        @(negedge clk); exp_q.push_back(v); tx_count++; req_in = 1'b1;
        while (!ack_out) @(negedge clk);
        check(req_in == 1'b1, "R8 ack_out rose while req_in high", req_in, 1);
        req_in = 1'b0;
        @(negedge clk);
        while (ack_out) @(negedge clk);
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin @(negedge clk); guard++; end
        repeat (N + 4) @(negedge clk);
    endtask

    // Monitor: pops and compares each item offered on req_out.
    initial begin : monitor
        int dly = 0;
        ack_in = 1'b0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (req_out && !hold_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 item without pending request", int'(data_out), -1);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(data_out == e, "R6 data_out order", int'(data_out), int'(e));
                end
                repeat (dly) @(negedge clk);
                dly = (dly + 1) % 4;
                check(req_out == 1'b1, "R8 req_out held until ack_in", req_out, 1);
                ack_in = 1'b1;
                while (req_out) @(negedge clk);
                ack_in = 1'b0;
                rx_count++;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin : main
        int lat;
        int rises;
        int last_change;
        logic prev_ack;
        req_in = 1'b0; data_in = '0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_out == 1'b0, "R1 req_out at reset", req_out, 0);
        check(ack_out == 1'b0, "R1 ack_out at reset", ack_out, 0);
        check(data_out == '0,  "R1 data_out at reset", int'(data_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req_out == 1'b0 && ack_out == 1'b0, "R1 idle after reset", int'({req_out, ack_out}), 0);

        // R4: latency through an empty chain
        data_in = 8'hA5;
        @(negedge clk);
        exp_q.push_back(8'hA5); tx_count++; req_in = 1'b1;
        @(negedge clk);
        check(ack_out == 1'b1, "R4 ack_out one clock after req_in", ack_out, 1);
        lat = 1;
        while (!req_out && lat < 50) begin @(negedge clk); lat++; end
        check(lat == N, "R4 req_out latency in clocks", lat, N);
        req_in = 1'b0;
        while (ack_out) @(negedge clk);
        drain();

        // R2, R3, R5, R6: flowing traffic with varied spacing
        for (int k = 0; k < 10; k++) send_item(W'(8'h10 + 8'(k * 37)), k % 3);
        drain();
        for (int k = 0; k < 8; k++) send_item(W'(8'hF0 ^ 8'(k)), 0);
        drain();
        check(exp_q.size() == 0, "R6 queue drained after flow", exp_q.size(), 0);

        // R7: stall the receiver, the chain fills
        hold_ack = 1'b1;
        fork
            begin
                for (int k = 0; k < N; k++) send_item(W'(8'hC0 + 8'(k)), 0);
            end
        join_none
        rises = 0; last_change = 0; prev_ack = ack_out;
        for (int t = 1; t <= 80; t++) begin
            @(negedge clk);
            if (ack_out != prev_ack) last_change = t;
            if (ack_out && !prev_ack) rises++;
            prev_ack = ack_out;
        end
        check(rises == (N + 1) / 2, "R7 acknowledges during stall", rises, (N + 1) / 2);
        check(last_change < 60, "R7 ack_out settled during stall", last_change, 59);
        check(req_out == 1'b1, "R7 req_out high while stalled", req_out, 1);
        hold_ack = 1'b0;
        repeat (200) @(negedge clk);
        drain();
        check(exp_q.size() == 0, "R7 all stalled items delivered", exp_q.size(), 0);
        check(rx_count == tx_count, "R6 items received equal sent", rx_count, tx_count);
        check(req_out == 1'b0 && ack_out == 1'b0, "R3 chain empty at end", int'({req_out, ack_out}), 0);
        finish_run();
    end

endmodule